// File: doc/BRIEF.md
# Repeating-Cycle Sequencer with Windowed Outputs

This block runs an experiment as a chain of identical, fixed-length cycles. A run command starts the chain. Each cycle counts coarse clock ticks from zero. When the count reaches the programmed length, the count returns to zero and a new cycle begins. The chain stops when the herald logic reports success, or when the overall run budget is spent. During every cycle each output line is driven high inside its own start/stop window, measured in ticks from the cycle start. The cycle end clips every window.

Software sets up the block through a register write port: a config word, the cycle length, one window word per output, and the run budget. Writing the run budget also starts the run. A combinational read port returns the status flags, the number of completed cycles, the remaining budget and the config word. Every run produces one result word carrying a reason code and the end time. The result word leaves on a valid/ready interface. It stays valid, with its data unchanged, until the consumer accepts it with ready high at a clock edge. While a result is waiting, no new run can start, so back-pressure on the result stalls the sequencer instead of dropping a result. Synchronisation with a partner device is not modelled; the master and standalone settings are only stored.

Top module: `cyc_seq`

## Requirements
- R1: After reset all outputs are low, res_valid is low, and the status, cycle count and remaining-time reads all return 0.
- R2: A write to address 0x00 stores the config word: bit 0 enable, bit 1 master role, bit 2 standalone. Read address 0x03 returns these three bits in bits 2:0.
- R3: Output i has its window word at write address 0x10+i, with the stop time in bits 31:16 and the start time in bits 15:0. While a run is active, output i is high when the cycle position p satisfies start <= p < stop. Position 0 is the clock cycle right after the edge that starts the run.
- R4: A stop time beyond the cycle length ends the pulse at the cycle end. A start time at or beyond the cycle length gives no pulse.
- R5: The cycle length is written at address 0x01 (0 acts as 1). After L ticks the position returns to 0. The completed-cycle count (read address 0x01) increases by one at every such restart. It does not increase on the edge that ends the run.
- R6: A write of D to address 0x02 starts a run. Without success, the run ends on the D-th clock edge after the write, with reason 0x3fff. The end time is the number of clock edges since reset that come before the ending edge.
- R7: herald_hit high at an edge during a run ends the run at that edge. The reason is then herald_match, and the end time is defined as in R6.
- R8: At run start the completed-cycle count is cleared, the remaining time (read address 0x02) is loaded with D, and both end flags are cleared. The remaining time then drops by one on every running edge, including the ending one, and stops at 0.
- R9: While enable is low, all outputs are low. A run write made while enable is low is ignored.
- R10: Each run produces exactly one result, with res_valid rising in the cycle after the ending edge. res_time and res_reason hold steady until res_ready is high at an edge. Run writes are ignored while a run is active or a result is waiting.
- R11: When success coincides with the timeout edge or with a cycle restart, success wins: the reason is herald_match and the cycle count does not increase.
- R12: Read address 0x00 returns the status: bit 2 last run timed out, bit 1 last run succeeded, bit 0 ready (enabled, idle and no result waiting).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| herald_hit | input | 1 | Success flag from herald logic |
| herald_match | input | 14 | Matching pattern bits, reported on success |
| out_lines | output | NOUT (4) | Windowed output lines |
| res_valid | output | 1 | Result word valid |
| res_ready | input | 1 | Consumer accepts the result |
| res_time | output | 32 | Tick count at the ending edge |
| res_reason | output | 14 | 0x3fff on timeout, else the herald match bits |

## Verification
Three events can fall on the same clock edge: herald success, budget expiry, and a cycle restart. The bench provokes all three at once. It sets the cycle length to 4 and the budget to 8, then raises herald_hit for exactly the eighth edge after the run write. It then judges the outcome in three ways: the result must carry the herald bits instead of 0x3fff, the status must show success, and the cycle count must read 1 instead of 2. A second overlap, a run write arriving while a result is held back by res_ready low, is checked by confirming that no second result appears and that the remaining time is left untouched.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int REASON_W = 14;

  localparam logic [REASON_W-1:0] TIMEOUT_CODE = 14'h3fff;

  // write map
  localparam logic [ADDR_W-1:0] WA_CFG      = 8'h00;
  localparam logic [ADDR_W-1:0] WA_CYCLE    = 8'h01;
  localparam logic [ADDR_W-1:0] WA_RUN      = 8'h02;
  localparam logic [ADDR_W-1:0] WA_WIN_BASE = 8'h10;

  // read map
  localparam logic [ADDR_W-1:0] RA_STATUS = 8'h00;
  localparam logic [ADDR_W-1:0] RA_NCYC   = 8'h01;
  localparam logic [ADDR_W-1:0] RA_REMAIN = 8'h02;
  localparam logic [ADDR_W-1:0] RA_CFG    = 8'h03;

  // window word layout
  localparam int WIN_START_LSB = 0;
  localparam int WIN_STOP_LSB  = 16;

  typedef struct packed {
    logic standalone;  // bit 2
    logic master;      // bit 1
    logic en;          // bit 0
  } cfg_t;
endpackage

// File: rtl/cs_regs.sv
module cs_regs
  import cs_pkg::*;
#(
  parameter int NOUT   = 4,
  parameter int TIME_W = 16,
  parameter int DUR_W  = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output cfg_t                         cfg,
  output logic [TIME_W-1:0]            cyc_len,
  output logic [NOUT-1:0][TIME_W-1:0]  win_start,
  output logic [NOUT-1:0][TIME_W-1:0]  win_stop,
  output logic                         run_go,
  output logic [DUR_W-1:0]             run_dur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      cyc_len <= '0;
    end else if (wr_en) begin
      if (wr_addr == WA_CFG)   cfg     <= cfg_t'(wr_data[2:0]);
      if (wr_addr == WA_CYCLE) cyc_len <= wr_data[TIME_W-1:0];
    end
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_win
    localparam logic [ADDR_W-1:0] MY_ADDR = WA_WIN_BASE + ADDR_W'(i);
    logic [TIME_W-1:0] start_q, stop_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q <= '0;
        stop_q  <= '0;
      end else if (wr_en && wr_addr == MY_ADDR) begin
        start_q <= wr_data[WIN_START_LSB +: TIME_W];
        stop_q  <= wr_data[WIN_STOP_LSB +: TIME_W];
      end
    end

    assign win_start[i] = start_q;
    assign win_stop[i]  = stop_q;
  end

  assign run_go  = wr_en && (wr_addr == WA_RUN);
  assign run_dur = wr_data[DUR_W-1:0];
endmodule

// File: rtl/cs_core.sv
module cs_core
  import cs_pkg::*;
#(
  parameter int TIME_W = 16,
  parameter int DUR_W  = 32,
  parameter int CNT_W  = 32,
  parameter int TS_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [TIME_W-1:0]   cyc_len,
  input  logic                run_go,
  input  logic [DUR_W-1:0]    run_dur,
  input  logic                herald_hit,
  input  logic [REASON_W-1:0] herald_match,
  input  logic                res_ready,
  output logic                running,
  output logic [TIME_W-1:0]   pos,
  output logic [CNT_W-1:0]    ncyc,
  output logic [DUR_W-1:0]    remain,
  output logic                flag_ok,
  output logic                flag_to,
  output logic                res_valid,
  output logic [TS_W-1:0]     res_time,
  output logic [REASON_W-1:0] res_reason
);
  logic [TS_W-1:0]   tick;
  logic [TIME_W-1:0] len_eff;
  logic [TIME_W:0]   pos_inc;
  logic              wrap, start, end_ok, end_to, finish;

  assign len_eff = (cyc_len == '0) ? TIME_W'(1) : cyc_len;
  assign pos_inc = {1'b0, pos} + (TIME_W+1)'(1);
  assign wrap    = pos_inc >= {1'b0, len_eff};
  assign start   = run_go && en && !running && !res_valid;
  assign end_ok  = running && herald_hit;
  assign end_to  = running && !herald_hit && (remain <= DUR_W'(1));
  assign finish  = end_ok || end_to;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick <= '0;
    else        tick <= tick + TS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running    <= 1'b0;
      pos        <= '0;
      ncyc       <= '0;
      remain     <= '0;
      flag_ok    <= 1'b0;
      flag_to    <= 1'b0;
      res_valid  <= 1'b0;
      res_time   <= '0;
      res_reason <= '0;
    end else begin
      if (start) begin
        running <= 1'b1;
        pos     <= '0;
        ncyc    <= '0;
        remain  <= run_dur;
        flag_ok <= 1'b0;
        flag_to <= 1'b0;
      end else if (running) begin
        remain <= (remain == '0) ? '0 : remain - DUR_W'(1);
        if (finish) begin
          running    <= 1'b0;
          pos        <= '0;
          res_valid  <= 1'b1;
          res_time   <= tick;
          res_reason <= end_ok ? herald_match : TIMEOUT_CODE;
          flag_ok    <= end_ok;
          flag_to    <= end_to;
        end else begin
          pos <= wrap ? '0 : pos_inc[TIME_W-1:0];
          if (wrap) ncyc <= ncyc + CNT_W'(1);
        end
      end
      if (res_valid && res_ready) res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cs_window.sv
module cs_window #(
  parameter int TIME_W = 16
) (
  input  logic [TIME_W-1:0] pos,
  input  logic [TIME_W-1:0] start_t,
  input  logic [TIME_W-1:0] stop_t,
  input  logic              active,
  output logic              lit
);
  // positions never reach the cycle length, so clipping falls out of the compare
  assign lit = active && (pos >= start_t) && (pos < stop_t);
endmodule

// File: rtl/cyc_seq.sv
module cyc_seq
  import cs_pkg::*;
#(
  parameter int NOUT   = 4,
  parameter int TIME_W = 16,
  parameter int DUR_W  = 32,
  parameter int CNT_W  = 32,
  parameter int TS_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                herald_hit,
  input  logic [REASON_W-1:0] herald_match,
  output logic [NOUT-1:0]     out_lines,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [TS_W-1:0]     res_time,
  output logic [REASON_W-1:0] res_reason
);
  cfg_t                        cfg_q;
  logic                        cfg_en;
  logic [TIME_W-1:0]           cyc_len;
  logic [NOUT-1:0][TIME_W-1:0] win_start, win_stop;
  logic                        run_go;
  logic [DUR_W-1:0]            run_dur;
  logic                        core_running, flag_ok, flag_to, ready;
  logic [TIME_W-1:0]           core_pos;
  logic [CNT_W-1:0]            core_ncyc;
  logic [DUR_W-1:0]            core_remain;

  cs_regs #(.NOUT(NOUT), .TIME_W(TIME_W), .DUR_W(DUR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg(cfg_q), .cyc_len(cyc_len), .win_start(win_start), .win_stop(win_stop),
    .run_go(run_go), .run_dur(run_dur)
  );

  assign cfg_en = cfg_q.en;

  cs_core #(.TIME_W(TIME_W), .DUR_W(DUR_W), .CNT_W(CNT_W), .TS_W(TS_W)) u_core (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .cyc_len(cyc_len),
    .run_go(run_go), .run_dur(run_dur),
    .herald_hit(herald_hit), .herald_match(herald_match), .res_ready(res_ready),
    .running(core_running), .pos(core_pos), .ncyc(core_ncyc), .remain(core_remain),
    .flag_ok(flag_ok), .flag_to(flag_to),
    .res_valid(res_valid), .res_time(res_time), .res_reason(res_reason)
  );

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    cs_window #(.TIME_W(TIME_W)) u_win (
      .pos(core_pos), .start_t(win_start[i]), .stop_t(win_stop[i]),
      .active(core_running && cfg_en), .lit(out_lines[i])
    );
  end

  assign ready = cfg_en && !core_running && !res_valid;

  always_comb begin
    case (rd_addr)
      RA_STATUS: rd_data = {{(DATA_W-3){1'b0}}, flag_to, flag_ok, ready};
      RA_NCYC:   rd_data = DATA_W'(core_ncyc);
      RA_REMAIN: rd_data = DATA_W'(core_remain);
      RA_CFG:    rd_data = {{(DATA_W-3){1'b0}}, cfg_q};
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cyc_seq_chk.sv
module cyc_seq_chk #(
  parameter int NOUT  = 4,
  parameter int CNT_W = 32,
  parameter int TS_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             running,
  input logic             res_valid,
  input logic             res_ready,
  input logic             flag_to,
  input logic [NOUT-1:0]  out_lines,
  input logic [TS_W-1:0]  res_time,
  input logic [13:0]      res_reason,
  input logic [CNT_W-1:0] ncyc
);
  assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> out_lines == '0);

  assert_start_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(cfg_en));

  assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_time) && $stable(res_reason));

  assert_one_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> !running && $past(running));

  assert_timeout_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && flag_to |-> res_reason == 14'h3fff);

  assert_cycle_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    running && $past(running) |-> (ncyc == $past(ncyc)) || (ncyc == $past(ncyc) + CNT_W'(1)));
endmodule

bind cyc_seq cyc_seq_chk #(.NOUT(NOUT), .CNT_W(CNT_W), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .running(core_running),
  .res_valid(res_valid), .res_ready(res_ready), .flag_to(flag_to),
  .out_lines(out_lines), .res_time(res_time), .res_reason(res_reason), .ncyc(core_ncyc)
);

// File: tb/cyc_seq_test.sv
module cyc_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NOUT = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        herald_hit = 1'b0;
  logic [13:0] herald_match = '0;
  logic [NOUT-1:0] out_lines;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] res_time;
  logic [13:0] res_reason;

  cyc_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .herald_hit(herald_hit), .herald_match(herald_match),
    .out_lines(out_lines), .res_valid(res_valid), .res_ready(res_ready),
    .res_time(res_time), .res_reason(res_reason)
  );

  typedef struct {
    logic [13:0] reason;
    logic [31:0] t;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int nchk = 0;
  int nerr = 0;
  logic [31:0] bt = '0;  // edges since reset release
  always @(posedge clk) if (rst_n) bt <= bt + 32'd1;

  int ws[NOUT] = '{2, 0, 12, 7};
  int we[NOUT] = '{5, 14, 20, 9};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic start_run(logic [31:0] d, output logic [31:0] t0);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = 8'h02; wr_data = d;
    t0 = bt;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  function automatic logic [NOUT-1:0] model_out(int p, int len);
    logic [NOUT-1:0] o;
    for (int i = 0; i < NOUT; i++) o[i] = (p >= ws[i]) && (p < we[i]) && (p < len);
    return o;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      exp_t e;
      if (sb.size() == 0) begin
        nchk++; nerr++;
        $display("FAIL R10 extra result act=%h/%h exp=none", res_reason, res_time);
      end else begin
        e = sb.pop_front();
        chk({e.tag, " reason"}, 32'(res_reason), 32'(e.reason));
        chk({e.tag, " end time"}, res_time, e.t);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R10 watchdog act=hung exp=finished");
    report();
  end

  initial begin
    logic [31:0] t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs", 32'(out_lines), 0);
    chk("R1 res_valid", 32'(res_valid), 0);
    rd("R1 status", 8'h00, 0);
    rd("R1 cycle count", 8'h01, 0);
    rd("R1 remaining", 8'h02, 0);

    // enable low: run ignored
    wr(8'h01, 10);
    for (int i = 0; i < NOUT; i++) wr(8'h10 + 8'(i), (32'(we[i]) << 16) | 32'(ws[i]));
    start_run(20, t0);
    for (int j = 0; j < 25; j++) begin
      @(negedge clk);
      if (j % 8 == 0) begin
        chk("R9 no run outputs", 32'(out_lines), 0);
        chk("R9 no result", 32'(res_valid), 0);
      end
    end
    rd("R9 remaining not loaded", 8'h02, 0);

    // config fields
    wr(8'h00, 32'h7);
    @(negedge clk);
    rd("R2 config readback", 8'h03, 7);
    rd("R12 ready flag", 8'h00, 1);
    wr(8'h00, 32'h5);
    @(negedge clk);
    rd("R2 config readback 2", 8'h03, 5);

    // timeout run with windows
    start_run(35, t0);
    sb.push_back('{14'h3fff, t0 + 32'd35, "R6 timeout"});
    for (int j = 0; j < 35; j++) begin
      @(negedge clk);
      chk("R3 R4 window", 32'(out_lines), 32'(model_out(j % 10, 10)));
    end
    @(negedge clk);
    chk("R6 R10 result strobe", 32'(res_valid), 1);
    chk("R6 outputs idle", 32'(out_lines), 0);
    rd("R12 status pending", 8'h00, 32'h4);
    @(negedge clk);
    rd("R12 status accepted", 8'h00, 32'h5);
    rd("R5 cycles completed", 8'h01, 3);
    rd("R8 remaining spent", 8'h02, 0);

    // success run
    start_run(1000, t0);
    @(negedge clk);
    rd("R8 cycle count cleared", 8'h01, 0);
    rd("R8 remaining loaded", 8'h02, 1000);
    rd("R8 flags cleared", 8'h00, 0);
    repeat (22) @(posedge clk);
    #1;
    herald_hit = 1'b1; herald_match = 14'h0005;
    sb.push_back('{14'h0005, bt, "R7 success"});
    @(posedge clk); #1;
    herald_hit = 1'b0;
    @(negedge clk);
    chk("R7 result strobe", 32'(res_valid), 1);
    @(negedge clk);
    rd("R7 R12 status success", 8'h00, 32'h3);
    rd("R5 R7 cycles at success", 8'h01, 2);
    rd("R8 remaining after success", 8'h02, 977);

    // success on the timeout edge and on a cycle restart
    wr(8'h01, 4);
    start_run(8, t0);
    repeat (7) @(posedge clk);
    #1;
    herald_hit = 1'b1; herald_match = 14'h002a;
    sb.push_back('{14'h002a, bt, "R11 coincident"});
    @(posedge clk); #1;
    herald_hit = 1'b0;
    @(negedge clk);
    chk("R11 result strobe", 32'(res_valid), 1);
    @(negedge clk);
    rd("R11 status success", 8'h00, 32'h3);
    rd("R11 no count on end", 8'h01, 1);

    // back-pressure and ignored run while pending
    wr(8'h01, 10);
    @(posedge clk); #1;
    res_ready = 1'b0;
    start_run(5, t0);
    sb.push_back('{14'h3fff, t0 + 32'd5, "R10 held"});
    repeat (5) @(posedge clk);
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      chk("R10 valid held", 32'(res_valid), 1);
      chk("R10 time stable", res_time, t0 + 32'd5);
    end
    wr(8'h02, 3);
    @(negedge clk);
    rd("R10 status while pending", 8'h00, 32'h4);
    rd("R10 run ignored", 8'h02, 0);
    @(posedge clk); #1;
    res_ready = 1'b1;
    repeat (12) @(negedge clk);
    chk("R10 no second result", 32'(res_valid), 0);
    chk("R10 scoreboard drained", 32'(sb.size()), 0);
    rd("R10 remaining untouched", 8'h02, 0);

    // enable dropped during a run
    start_run(30, t0);
    sb.push_back('{14'h3fff, t0 + 32'd30, "R6 R9 disabled run"});
    wr(8'h00, 32'h0);
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      chk("R9 outputs forced low", 32'(out_lines), 0);
    end
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk("R9 run completed", 32'(sb.size()), 0);
    rd("R9 R12 status disabled", 8'h00, 32'h4);

    report();
  end
endmodule